// File: doc/BRIEF.md
# Edge Interrupt Acknowledge Coalescing Tracker

This block follows a single edge-triggered interrupt source, typically a periodic timer tick, after it has been handed to a group of CPUs. It keeps one bit per CPU, set for each CPU that took the latest delivery and has not yet signalled end-of-interrupt. It also keeps a count of those outstanding acknowledgements. While the count is non-zero, the source is reported as coalesced, and any new delivery result is refused until the last acknowledgement arrives.

Three sources change the state: the delivery result (which CPUs were reached, plus a failure flag), per-CPU acknowledgements, and resynchronisation against each CPU's live pending indication. A single-CPU resync corrects one bit and moves the count by one. A full resync rebuilds the whole state by visiting one CPU per clock cycle. The full walk starts on request, and it also starts by itself when an acknowledgement or a resync would drive the count below zero.

Destination matching and delivery take place outside the block. The block receives the per-CPU destination match as an input vector.

Top module: `eoi_coal_tracker`

## Requirements
- R1: `coalesced_o` is high exactly when `pend_cnt_o` is non-zero.
- R2: An accepted delivery loads `pend_map_o` with `dlv_map_i`. The count becomes the number of set bits in `dlv_map_i`. If `dlv_err_i` is high, the count becomes zero and the map is still loaded.
- R3: A delivery is accepted only when the count is zero and no full walk is running. Otherwise the delivery leaves map and count unchanged.
- R4: An acknowledgement on `ack_i[c]` clears map bit c and decrements the count, but only if bit c was set. Acknowledgements on clear bits have no effect. Several acknowledgements in one cycle are each applied.
- R5: If acknowledgements, or a single-CPU resync that clears a bit, would take the count below zero, map and count are cleared in the next cycle and a full walk starts.
- R6: `clear_i` clears map and count, stops any running walk, and has priority over every other input.
- R7: A single-CPU resync (`sync_one_i`, CPU `sync_cpu_i`) acts only if `dest_match_i` is high for that CPU and `live_pend_i` differs from the map bit. It then copies the live value into the bit and moves the count by one. A CPU without a destination match is skipped.
- R8: A full walk, started by `sync_all_i` or by R5, clears map and count in its first cycle. It then visits CPU 0 up to NUM_CPU-1, one per cycle, and sets the bit and increments the count for each CPU with both a destination match and live pending. `sync_busy_o` is high during the NUM_CPU visiting cycles. `sync_done_o` pulses for one cycle after the last visit.
- R9: An acknowledgement and a single-CPU resync in the same cycle both take effect. The acknowledgement is applied first, and the resync compares against the map as it stands after the acknowledgement.
- R10: While `sync_busy_o` is high, deliveries, acknowledgements and single-CPU resyncs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the tracking state |
| dlv_valid_i | input | 1 | Delivery result valid |
| dlv_map_i | input | NUM_CPU | CPUs that accepted the delivery |
| dlv_err_i | input | 1 | Delivery reported failure; count is taken as zero |
| ack_i | input | NUM_CPU | Per-CPU end-of-interrupt acknowledgements |
| live_pend_i | input | NUM_CPU | Per-CPU live pending indication for this source |
| dest_match_i | input | NUM_CPU | Per-CPU destination match for this source |
| sync_one_i | input | 1 | Single-CPU resync request |
| sync_cpu_i | input | $clog2(NUM_CPU) | CPU index for the single-CPU resync |
| sync_all_i | input | 1 | Full resync request |
| coalesced_o | output | 1 | New edges would be coalesced |
| pend_cnt_o | output | $clog2(NUM_CPU)+1 | Outstanding acknowledgement count |
| pend_map_o | output | NUM_CPU | Per-CPU outstanding acknowledgement map |
| sync_busy_o | output | 1 | Full walk in progress |
| sync_done_o | output | 1 | One-cycle pulse at the end of a full walk |

## Verification
The two functions that can fall in the same cycle are an acknowledgement and a single-CPU resync. The bench drives both in one cycle, on CPU 0 and CPU 7, with the live indication of CPU 7 low. It then requires both bits cleared and the count down by two.

A second collision is an acknowledgement against a map that was loaded by a failed delivery, which has count zero. That acknowledgement must take the underflow path: it starts a full walk, and the walk must rebuild the state from the live indications rather than let the count wrap.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/eoi_pop_count.sv
module eoi_pop_count #(
  parameter int unsigned N = 8,
  parameter int unsigned W = $clog2(N) + 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      cnt_o = cnt_o + W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/eoi_ack_unit.sv
module eoi_ack_unit #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned CNT_W  = $clog2(NUM_CPU) + 1,
  localparam int unsigned IDX_W  = $clog2(NUM_CPU)
) (
  input  logic [NUM_CPU-1:0] map_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_CPU-1:0] ack_i,
  input  logic               sync_one_i,
  input  logic [IDX_W-1:0]   sync_cpu_i,
  input  logic [NUM_CPU-1:0] live_pend_i,
  input  logic [NUM_CPU-1:0] dest_match_i,
  output logic [NUM_CPU-1:0] map_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               underflow_o
);
  logic [CNT_W-1:0]   n_ack;
  logic [NUM_CPU-1:0] map_a;
  logic [CNT_W-1:0]   cnt_a;
  logic [NUM_CPU-1:0] sel_oh;
  logic               sel_ok, sel_old, sel_new, do_sync;

  eoi_pop_count #(.N(NUM_CPU), .W(CNT_W)) u_ack_pop (
    .vec_i (ack_i & map_i),
    .cnt_o (n_ack)
  );

  assign map_a   = map_i & ~ack_i;
  assign cnt_a   = cnt_i - n_ack;
  assign sel_ok  = (32'(sync_cpu_i) < NUM_CPU);
  assign sel_oh  = sel_ok ? (NUM_CPU'(1) << sync_cpu_i) : '0;
  assign sel_old = |(map_a & sel_oh);
  assign sel_new = |(live_pend_i & sel_oh);
  assign do_sync = sync_one_i && |(dest_match_i & sel_oh) && (sel_old != sel_new);

  always_comb begin
    map_o       = map_a;
    cnt_o       = cnt_a;
    underflow_o = (n_ack > cnt_i);
    if (!underflow_o && do_sync) begin
      if (sel_new) begin
        map_o = map_a | sel_oh;
        cnt_o = cnt_a + CNT_W'(1);
      end else if (cnt_a == '0) begin
        underflow_o = 1'b1;
      end else begin
        map_o = map_a & ~sel_oh;
        cnt_o = cnt_a - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/eoi_walk_ctrl.sv
module eoi_walk_ctrl
  import eoi_trk_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_CPU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  walk_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WALK_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        st_q  <= WALK_IDLE;
        idx_q <= '0;
      end else if (start_i) begin
        st_q  <= WALK_RUN;
        idx_q <= '0;
      end else if (st_q == WALK_RUN) begin
        if (32'(idx_q) == NUM_CPU - 1) begin
          st_q   <= WALK_IDLE;
          idx_q  <= '0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o = (st_q == WALK_RUN);
  assign idx_o  = idx_q;
  assign done_o = done_q;
endmodule

// File: rtl/eoi_coal_tracker.sv
module eoi_coal_tracker #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned CNT_W  = $clog2(NUM_CPU) + 1,
  localparam int unsigned IDX_W  = $clog2(NUM_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               dlv_valid_i,
  input  logic [NUM_CPU-1:0] dlv_map_i,
  input  logic               dlv_err_i,
  input  logic [NUM_CPU-1:0] ack_i,
  input  logic [NUM_CPU-1:0] live_pend_i,
  input  logic [NUM_CPU-1:0] dest_match_i,
  input  logic               sync_one_i,
  input  logic [IDX_W-1:0]   sync_cpu_i,
  input  logic               sync_all_i,
  output logic               coalesced_o,
  output logic [CNT_W-1:0]   pend_cnt_o,
  output logic [NUM_CPU-1:0] pend_map_o,
  output logic               sync_busy_o,
  output logic               sync_done_o
);
  logic [NUM_CPU-1:0] map_q, map_d, map_ack;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_ack, dlv_cnt;
  logic               underflow, busy, start_walk;
  logic [IDX_W-1:0]   walk_idx;
  logic [NUM_CPU-1:0] walk_oh;
  logic               walk_hit;

  eoi_pop_count #(.N(NUM_CPU), .W(CNT_W)) u_dlv_pop (
    .vec_i (dlv_map_i),
    .cnt_o (dlv_cnt)
  );

  eoi_ack_unit #(.NUM_CPU(NUM_CPU)) u_ack (
    .map_i        (map_q),
    .cnt_i        (cnt_q),
    .ack_i        (ack_i),
    .sync_one_i   (sync_one_i),
    .sync_cpu_i   (sync_cpu_i),
    .live_pend_i  (live_pend_i),
    .dest_match_i (dest_match_i),
    .map_o        (map_ack),
    .cnt_o        (cnt_ack),
    .underflow_o  (underflow)
  );

  assign start_walk = sync_all_i | (underflow & ~busy);

  eoi_walk_ctrl #(.NUM_CPU(NUM_CPU)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (clear_i),
    .start_i (start_walk),
    .busy_o  (busy),
    .idx_o   (walk_idx),
    .done_o  (sync_done_o)
  );

  assign walk_oh  = NUM_CPU'(1) << walk_idx;
  assign walk_hit = |(walk_oh & dest_match_i & live_pend_i);

  always_comb begin
    map_d = map_q;
    cnt_d = cnt_q;
    if (clear_i || start_walk) begin
      map_d = '0;
      cnt_d = '0;
    end else if (busy) begin
      if (walk_hit) begin
        map_d = map_q | walk_oh;
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (dlv_valid_i && cnt_q == '0) begin
      map_d = dlv_map_i;
      cnt_d = dlv_err_i ? '0 : dlv_cnt;
    end else begin
      map_d = map_ack;
      cnt_d = cnt_ack;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
      cnt_q <= '0;
    end else begin
      map_q <= map_d;
      cnt_q <= cnt_d;
    end
  end

  assign coalesced_o = (cnt_q != '0);
  assign pend_cnt_o  = cnt_q;
  assign pend_map_o  = map_q;
  assign sync_busy_o = busy;
endmodule

// File: rtl/eoi_coal_tracker_chk.sv
module eoi_coal_tracker_chk #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned CNT_W  = $clog2(NUM_CPU) + 1,
  localparam int unsigned IDX_W  = $clog2(NUM_CPU)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               dlv_valid_i,
  input logic [NUM_CPU-1:0] dlv_map_i,
  input logic               dlv_err_i,
  input logic [NUM_CPU-1:0] ack_i,
  input logic [NUM_CPU-1:0] live_pend_i,
  input logic [NUM_CPU-1:0] dest_match_i,
  input logic               sync_one_i,
  input logic [IDX_W-1:0]   sync_cpu_i,
  input logic               sync_all_i,
  input logic               coalesced_o,
  input logic [CNT_W-1:0]   pend_cnt_o,
  input logic [NUM_CPU-1:0] pend_map_o,
  input logic               sync_busy_o,
  input logic               sync_done_o
);
  logic quiet;
  assign quiet = !clear_i && !sync_all_i && !sync_one_i && (ack_i == '0);

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pend_cnt_o) <= NUM_CPU);

  assert_dlv_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && dlv_valid_i && !coalesced_o && !sync_busy_o)
      |=> (pend_map_o == $past(dlv_map_i)));

  assert_dlv_refused_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && dlv_valid_i && coalesced_o && !sync_busy_o)
      |=> ($stable(pend_map_o) && $stable(pend_cnt_o)));

  assert_ack_clear_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !sync_all_i && !sync_one_i && !sync_busy_o && !dlv_valid_i
     && ((ack_i & pend_map_o) == '0))
      |=> ($stable(pend_map_o) && $stable(pend_cnt_o)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pend_cnt_o == '0 && pend_map_o == '0 && !sync_busy_o));

  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_busy_o) && !$past(clear_i) && !$past(sync_all_i) |-> sync_done_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |=> !sync_done_o);

  assert_busy_ignores_dlv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_busy_o && !clear_i && !sync_all_i && dlv_valid_i && (dlv_map_i != '0)
     && (dest_match_i & live_pend_i) == '0)
      |=> $stable(pend_map_o));
endmodule

bind eoi_coal_tracker eoi_coal_tracker_chk #(.NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/eoi_coal_tracker_tb.sv
`timescale 1ns/1ps
module eoi_coal_tracker_tb;
  localparam int unsigned NUM_CPU = 8;
  localparam int unsigned CNT_W   = $clog2(NUM_CPU) + 1;
  localparam int unsigned IDX_W   = $clog2(NUM_CPU);

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               clear_i = 1'b0;
  logic               dlv_valid_i = 1'b0;
  logic [NUM_CPU-1:0] dlv_map_i = '0;
  logic               dlv_err_i = 1'b0;
  logic [NUM_CPU-1:0] ack_i = '0;
  logic [NUM_CPU-1:0] live_pend_i = '0;
  logic [NUM_CPU-1:0] dest_match_i = '1;
  logic               sync_one_i = 1'b0;
  logic [IDX_W-1:0]   sync_cpu_i = '0;
  logic               sync_all_i = 1'b0;
  logic               coalesced_o;
  logic [CNT_W-1:0]   pend_cnt_o;
  logic [NUM_CPU-1:0] pend_map_o;
  logic               sync_busy_o;
  logic               sync_done_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  eoi_coal_tracker #(.NUM_CPU(NUM_CPU)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic state(string req, int map, int cnt, int busy);
    chk({req, " map"}, int'(pend_map_o), map);
    chk({req, " cnt"}, int'(pend_cnt_o), cnt);
    chk({req, " coalesced"}, int'(coalesced_o), int'(cnt != 0));
    chk({req, " busy"}, int'(sync_busy_o), busy);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
    clear_i = 0; dlv_valid_i = 0; dlv_err_i = 0; ack_i = '0;
    sync_one_i = 0; sync_all_i = 0;
  endtask

  task automatic t_reset();
    state("R6 reset", 0, 0, 0);
  endtask

  task automatic t_delivery();
    dlv_valid_i = 1; dlv_map_i = 8'h16; cyc();
    state("R2 load", 'h16, 3, 0);                 // R1 coalesced
    dlv_valid_i = 1; dlv_map_i = 8'hFF; cyc();
    state("R3 refused while pending", 'h16, 3, 0);
  endtask

  task automatic t_ack();
    ack_i = 8'h01; cyc();
    state("R4 ack on clear bit", 'h16, 3, 0);
    ack_i = 8'h02; cyc();
    state("R4 ack one", 'h14, 2, 0);
    ack_i = 8'h14; cyc();
    state("R4 ack two", 0, 0, 0);
    dlv_valid_i = 1; dlv_map_i = 8'h00; cyc();
    state("R2 empty delivery", 0, 0, 0);
  endtask

  task automatic t_clear();
    dlv_valid_i = 1; dlv_map_i = 8'hC0; cyc();
    clear_i = 1; ack_i = 8'h40; sync_all_i = 1; cyc();
    state("R6 clear", 0, 0, 0);
  endtask

  task automatic t_underflow_walk();
    dlv_valid_i = 1; dlv_err_i = 1; dlv_map_i = 8'h05; cyc();
    state("R2 failed delivery", 'h05, 0, 0);
    live_pend_i = 8'h81; dest_match_i = 8'hFF;
    ack_i = 8'h01; cyc();
    state("R5 underflow starts walk", 0, 0, 1);
    for (int i = 0; i < NUM_CPU; i++) begin
      if (i == NUM_CPU - 1) chk("R8 busy last visit", int'(sync_busy_o), 1);
      cyc();
    end
    state("R8 walk result", 'h81, 2, 0);
    chk("R8 done pulse", int'(sync_done_o), 1);
    cyc();
    chk("R8 done one cycle", int'(sync_done_o), 0);
  endtask

  task automatic t_sync_one();
    live_pend_i = 8'h89; sync_one_i = 1; sync_cpu_i = 3; cyc();
    state("R7 resync set", 'h89, 3, 0);
    live_pend_i = 8'hA9; dest_match_i = 8'hDF; sync_one_i = 1; sync_cpu_i = 5; cyc();
    state("R7 resync skipped", 'h89, 3, 0);
    dest_match_i = 8'hFF; live_pend_i = 8'h09;
    ack_i = 8'h01; sync_one_i = 1; sync_cpu_i = 7; cyc();
    state("R9 ack plus resync", 'h08, 1, 0);
  endtask

  task automatic t_busy_ignore();
    live_pend_i = 8'h00; sync_all_i = 1; cyc();
    state("R8 walk start", 0, 0, 1);
    dlv_valid_i = 1; dlv_map_i = 8'hFF; cyc();
    chk("R10 delivery ignored", int'(pend_map_o), 0);
    ack_i = 8'h01; sync_one_i = 1; sync_cpu_i = 0; live_pend_i = 8'h00; cyc();
    chk("R10 resync ignored", int'(pend_map_o), 0);
    for (int i = 0; i < NUM_CPU; i++) begin
      if (sync_done_o) break;
      cyc();
    end
    state("R10 after walk", 0, 0, 0);
    dlv_valid_i = 1; dlv_map_i = 8'h03; cyc();
    state("R3 accepted at zero", 'h03, 2, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_delivery();
    t_ack();
    t_clear();
    t_underflow_walk();
    t_sync_one();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule